// File: doc/BRIEF.md
# Serial Port Register and Status Unit

This block is the byte-wide register file and flag logic of an asynchronous serial port. A host reads and writes eight byte-sized offsets through a simple single-cycle bus. The unit stores the mode, bit-rate, control, transmit and receive data, and two auxiliary mode bytes. It also keeps the status flags that track received data, transmit progress and receive errors. Bit serialization and baud timing live in neighbouring blocks. This unit hands each transmit byte to the serializer and takes each finished byte from the deserializer.

Received bytes arrive on a valid/ready stream. `rx_ready` follows the receive-enable control bit, and a byte moves only on a cycle where both `rx_valid` and `rx_ready` are high. While receive is disabled the producer must hold or drop its byte; this unit never stores one. The transmit side is a plain start pulse. The unit launches a byte only when the serializer is idle (transmit end set) or has just reported `tx_done`, so the serializer never needs back-pressure.

Four interrupt outputs are driven. The receive and transmit-empty interrupts are one-cycle pulses. The receive-error and transmit-end interrupts are levels. All interrupts, `tx_start` and `tx_data` are registered, so they change one cycle after the event that causes them. `bus_rdata` is combinational from the current register state, and the side effects of a read take effect at the end of that access cycle.

Top module: `uart_regfile`

## Requirements
- R1: After reset the offsets read: 0 mode 0x00, 1 bit rate 0xFF, 2 control 0x00, 3 transmit data 0xFF, 4 status 0x84, 5 receive data 0x00, 6 and 7 auxiliary 0x00.
- R2: Writes to offset 0 (mode) and offset 1 (bit rate) are ignored while control bit 5 (transmit enable) or bit 4 (receive enable) is set.
- R3: `rx_ready` equals control bit 4. An accepted byte arriving while status bit 6 (receive full) is clear is stored, bit 6 is set, and `irq_rx` pulses for one cycle if control bit 6 (receive interrupt enable) is set.
- R4: An accepted byte arriving while status bit 6 is set leaves the stored byte unchanged and sets status bit 5 (overrun). If control bit 6 is set, it also raises the `irq_err` level.
- R5: Reading offset 5 returns the stored byte and clears status bit 6. Writing offset 5 has no effect.
- R6: A write to offset 4 changes only status bit 0 and the error bits 5:3 (overrun, framing, parity), which take the written values.
- R7: A status write drops `irq_err` only when the error bits captured at the last status read were nonzero and the error bits after the write are all zero.
- R8: A `line_break` pulse sets status bit 4 (framing error) and raises `irq_err` if control bit 6 is set.
- R9: A control write with bit 6 clear drops `irq_err`, and one with bit 2 (transmit-end interrupt enable) clear drops `irq_tend`. A control write with bit 5 set sets status bits 7 and 2 and pulses `irq_txe` if its bit 7 (transmit interrupt enable) is set.
- R10: A write to offset 3 while status bit 2 (transmit end) is set launches the byte. `tx_start` pulses with `tx_data` equal to the byte, bit 2 clears, bit 7 stays set, `irq_tend` drops and `irq_txe` pulses if enabled. A write while bit 2 is clear stores the byte and clears status bit 7.
- R11: On `tx_done`, a pending byte (status bit 7 clear) is launched as in R10. Otherwise status bit 2 is set and `irq_tend` rises as a level if control bit 2 is set.
- R12: Offsets at or above 8 read 0xFF, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive stream accepts a byte |
| rx_data | input | 8 | Received byte |
| line_break | input | 1 | One-cycle break detection pulse |
| tx_start | output | 1 | Launch pulse to the serializer |
| tx_data | output | 8 | Byte to serialize |
| tx_done | input | 1 | Serializer finished a character |
| irq_rx | output | 1 | Receive interrupt pulse |
| irq_err | output | 1 | Receive error interrupt level |
| irq_txe | output | 1 | Transmit-empty interrupt pulse |
| irq_tend | output | 1 | Transmit-end interrupt level |

## Verification
The hardest state to reach is the error interrupt release. It depends on a status snapshot taken at an earlier read, so the same clearing write must drop the interrupt in one history and leave it high in another. The stimulus first forces an overrun by offering two bytes without reading, then reads status and writes zero to see the release. Next it takes a status read while the errors are clear, creates a second overrun, and writes zero without reading, so the interrupt must stay high. The transmit-end path is reached the same way: a byte is queued while another is in flight, then two `tx_done` pulses drive the relaunch and the idle case in turn.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int BYTE_W = 8;
  localparam int WIN    = 8;
  localparam int ERR_N  = 3;
  localparam int ERR_PAR = 0;
  localparam int ERR_FRM = 1;
  localparam int ERR_OVR = 2;

  typedef enum logic [2:0] {
    OFS_MODE = 3'd0,
    OFS_RATE = 3'd1,
    OFS_CTRL = 3'd2,
    OFS_TXD  = 3'd3,
    OFS_STAT = 3'd4,
    OFS_RXD  = 3'd5,
    OFS_AUXA = 3'd6,
    OFS_AUXB = 3'd7
  } ofs_e;

  typedef struct packed {
    logic       txie;
    logic       rxie;
    logic       txen;
    logic       rxen;
    logic       mpie;
    logic       teie;
    logic [1:0] clken;
  } ctrl_t;

  localparam logic [BYTE_W-1:0] RST_MODE = 8'h00;
  localparam logic [BYTE_W-1:0] RST_RATE = 8'hFF;
  localparam logic [BYTE_W-1:0] RST_TXD  = 8'hFF;
  localparam logic [BYTE_W-1:0] RST_RXD  = 8'h00;
  localparam logic [BYTE_W-1:0] RST_AUX  = 8'h00;
  localparam logic [BYTE_W-1:0] NO_REG   = 8'hFF;
endpackage

// File: rtl/uart_rf_rx.sv
module uart_rf_rx
  import uart_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_rxd,
  input  logic              rd_stat,
  input  logic              wr_stat,
  input  logic [ERR_N-1:0]  wr_err,
  input  logic              ctrl_wr,
  input  logic              rie,
  input  logic              rx_fire,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              brk,
  output logic [BYTE_W-1:0] rxd,
  output logic              rdrf,
  output logic [ERR_N-1:0]  err,
  output logic              irq_rx,
  output logic              irq_err
);
  logic [BYTE_W-1:0] rxd_q, rxd_n;
  logic              rdrf_q, rdrf_n;
  logic [ERR_N-1:0]  err_q, err_n, snap_q, snap_n;
  logic              eri_q, eri_n, rxi_q, rxi_n;

  always_comb begin
    rxd_n  = rxd_q;
    rdrf_n = rdrf_q;
    err_n  = err_q;
    snap_n = snap_q;
    eri_n  = eri_q;
    rxi_n  = 1'b0;
    if (rd_stat) snap_n = err_q;
    if (rd_rxd) rdrf_n = 1'b0;
    if (ctrl_wr && !rie) eri_n = 1'b0;
    if (wr_stat) begin
      err_n = wr_err;
      if ((snap_q != '0) && (err_n == '0)) eri_n = 1'b0;
    end
    if (rx_fire) begin
      if (rdrf_n) begin
        err_n[ERR_OVR] = 1'b1;
        if (rie) eri_n = 1'b1;
      end else begin
        rxd_n  = rx_byte;
        rdrf_n = 1'b1;
        rxi_n  = rie;
      end
    end
    if (brk) begin
      err_n[ERR_FRM] = 1'b1;
      if (rie) eri_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_q  <= RST_RXD;
      rdrf_q <= 1'b0;
      err_q  <= '0;
      snap_q <= '0;
      eri_q  <= 1'b0;
      rxi_q  <= 1'b0;
    end else begin
      rxd_q  <= rxd_n;
      rdrf_q <= rdrf_n;
      err_q  <= err_n;
      snap_q <= snap_n;
      eri_q  <= eri_n;
      rxi_q  <= rxi_n;
    end
  end

  assign rxd     = rxd_q;
  assign rdrf    = rdrf_q;
  assign err     = err_q;
  assign irq_rx  = rxi_q;
  assign irq_err = eri_q;
endmodule

// File: rtl/uart_rf_tx.sv
module uart_rf_tx
  import uart_rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              w_te,
  input  logic              tie,
  input  logic              teie,
  input  logic              wr_txd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              tx_done,
  output logic [BYTE_W-1:0] txd,
  output logic              tdre,
  output logic              tend,
  output logic              tx_start,
  output logic              irq_txe,
  output logic              irq_tend
);
  logic [BYTE_W-1:0] txd_q, txd_n;
  logic tdre_q, tdre_n, tend_q, tend_n, tei_q, tei_n;
  logic start_q, start_n, txi_q, txi_n;

  always_comb begin
    txd_n   = txd_q;
    tdre_n  = tdre_q;
    tend_n  = tend_q;
    tei_n   = tei_q;
    start_n = 1'b0;
    txi_n   = 1'b0;
    if (ctrl_wr) begin
      if (w_te) begin
        tdre_n = 1'b1;
        tend_n = 1'b1;
        txi_n  = tie;
      end
      if (!teie) tei_n = 1'b0;
    end
    if (wr_txd) begin
      txd_n = wdata;
      if (tend_n) begin
        tend_n  = 1'b0;
        tdre_n  = 1'b1;
        tei_n   = 1'b0;
        start_n = 1'b1;
        txi_n   = tie;
      end else begin
        tdre_n = 1'b0;
      end
    end
    if (tx_done && !start_n) begin
      if (!tdre_n) begin
        tend_n  = 1'b0;
        tdre_n  = 1'b1;
        tei_n   = 1'b0;
        start_n = 1'b1;
        txi_n   = tie;
      end else begin
        tend_n = 1'b1;
        if (teie) tei_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q   <= RST_TXD;
      tdre_q  <= 1'b1;
      tend_q  <= 1'b1;
      tei_q   <= 1'b0;
      start_q <= 1'b0;
      txi_q   <= 1'b0;
    end else begin
      txd_q   <= txd_n;
      tdre_q  <= tdre_n;
      tend_q  <= tend_n;
      tei_q   <= tei_n;
      start_q <= start_n;
      txi_q   <= txi_n;
    end
  end

  assign txd      = txd_q;
  assign tdre     = tdre_q;
  assign tend     = tend_q;
  assign tx_start = start_q;
  assign irq_txe  = txi_q;
  assign irq_tend = tei_q;
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              line_break,
  output logic              tx_start,
  output logic [7:0]        tx_data,
  input  logic              tx_done,
  output logic              irq_rx,
  output logic              irq_err,
  output logic              irq_txe,
  output logic              irq_tend
);
  localparam int OFS_W = $clog2(WIN);

  logic       hit;
  ofs_e       ofs;
  logic       wr_mode, wr_rate, wr_ctrl, wr_txd, wr_stat, wr_auxa, wr_auxb;
  logic       rd_stat, rd_rxd;
  logic       port_on;
  ctrl_t      ctrl_q, ctrl_w;
  logic       rie_eff, tie_eff, teie_eff;
  logic [BYTE_W-1:0] mode_q, rate_q, auxa_q, auxb_q;
  logic       mpbt_q;
  logic       rx_fire;
  logic [BYTE_W-1:0] rxd, txd;
  logic       rdrf, tdre, tend;
  logic [ERR_N-1:0] err;
  logic [BYTE_W-1:0] stat;

  assign hit     = bus_valid && (bus_addr < ADDR_W'(WIN));
  assign ofs     = ofs_e'(bus_addr[OFS_W-1:0]);
  assign wr_mode = hit && bus_write && (ofs == OFS_MODE);
  assign wr_rate = hit && bus_write && (ofs == OFS_RATE);
  assign wr_ctrl = hit && bus_write && (ofs == OFS_CTRL);
  assign wr_txd  = hit && bus_write && (ofs == OFS_TXD);
  assign wr_stat = hit && bus_write && (ofs == OFS_STAT);
  assign wr_auxa = hit && bus_write && (ofs == OFS_AUXA);
  assign wr_auxb = hit && bus_write && (ofs == OFS_AUXB);
  assign rd_stat = hit && !bus_write && (ofs == OFS_STAT);
  assign rd_rxd  = hit && !bus_write && (ofs == OFS_RXD);

  assign ctrl_w   = ctrl_t'(bus_wdata);
  assign port_on  = ctrl_q.txen || ctrl_q.rxen;
  assign rie_eff  = wr_ctrl ? ctrl_w.rxie : ctrl_q.rxie;
  assign tie_eff  = wr_ctrl ? ctrl_w.txie : ctrl_q.txie;
  assign teie_eff = wr_ctrl ? ctrl_w.teie : ctrl_q.teie;

  assign rx_ready = ctrl_q.rxen;
  assign rx_fire  = rx_valid && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RST_MODE;
      rate_q <= RST_RATE;
      ctrl_q <= '0;
      auxa_q <= RST_AUX;
      auxb_q <= RST_AUX;
      mpbt_q <= 1'b0;
    end else begin
      if (wr_mode && !port_on) mode_q <= bus_wdata;
      if (wr_rate && !port_on) rate_q <= bus_wdata;
      if (wr_ctrl) ctrl_q <= ctrl_w;
      if (wr_auxa) auxa_q <= bus_wdata;
      if (wr_auxb) auxb_q <= bus_wdata;
      if (wr_stat) mpbt_q <= bus_wdata[0];
    end
  end

  uart_rf_rx u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_rxd  (rd_rxd),
    .rd_stat (rd_stat),
    .wr_stat (wr_stat),
    .wr_err  (bus_wdata[5:3]),
    .ctrl_wr (wr_ctrl),
    .rie     (rie_eff),
    .rx_fire (rx_fire),
    .rx_byte (rx_data),
    .brk     (line_break),
    .rxd     (rxd),
    .rdrf    (rdrf),
    .err     (err),
    .irq_rx  (irq_rx),
    .irq_err (irq_err)
  );

  uart_rf_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr  (wr_ctrl),
    .w_te     (ctrl_w.txen),
    .tie      (tie_eff),
    .teie     (teie_eff),
    .wr_txd   (wr_txd),
    .wdata    (bus_wdata),
    .tx_done  (tx_done),
    .txd      (txd),
    .tdre     (tdre),
    .tend     (tend),
    .tx_start (tx_start),
    .irq_txe  (irq_txe),
    .irq_tend (irq_tend)
  );

  assign tx_data = txd;
  assign stat    = {tdre, rdrf, err[ERR_OVR], err[ERR_FRM], err[ERR_PAR],
                    tend, 1'b0, mpbt_q};

  always_comb begin
    bus_rdata = NO_REG;
    if (bus_addr < ADDR_W'(WIN)) begin
      unique case (ofs)
        OFS_MODE: bus_rdata = mode_q;
        OFS_RATE: bus_rdata = rate_q;
        OFS_CTRL: bus_rdata = ctrl_q;
        OFS_TXD:  bus_rdata = txd;
        OFS_STAT: bus_rdata = stat;
        OFS_RXD:  bus_rdata = rxd;
        OFS_AUXA: bus_rdata = auxa_q;
        OFS_AUXB: bus_rdata = auxb_q;
        default:  bus_rdata = NO_REG;
      endcase
    end
  end
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_mode,
  input logic       port_on,
  input logic [7:0] mode_q,
  input logic       rx_fire,
  input logic       rd_rxd,
  input logic       rdrf,
  input logic [7:0] rxd,
  input logic       irq_rx,
  input logic       irq_err,
  input logic [2:0] err,
  input logic       tx_start,
  input logic       tdre,
  input logic       tend,
  input logic       irq_tend
);
  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && port_on) |=> $stable(mode_q)); // R2

  AST_RXI_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> rdrf); // R3

  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && rdrf && !rd_rxd) |=> $stable(rxd)); // R4

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && !rx_fire) |=> !rdrf); // R5

  AST_ERI_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_err) |-> (err != 3'b000)); // R8

  AST_LAUNCH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (tdre && !tend)); // R10

  AST_TEI_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tend |-> tend); // R11
endmodule

bind uart_regfile uart_regfile_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_mode  (wr_mode),
  .port_on  (port_on),
  .mode_q   (mode_q),
  .rx_fire  (rx_fire),
  .rd_rxd   (rd_rxd),
  .rdrf     (rdrf),
  .rxd      (rxd),
  .irq_rx   (irq_rx),
  .irq_err  (irq_err),
  .err      (err),
  .tx_start (tx_start),
  .tdre     (tdre),
  .tend     (tend),
  .irq_tend (irq_tend)
);

// File: tb/tb_uart_regfile.sv
`timescale 1ns/100ps
module tb_uart_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       rx_valid = 1'b0, rx_ready;
  logic [7:0] rx_data = '0;
  logic       line_break = 1'b0;
  logic       tx_start;
  logic [7:0] tx_data;
  logic       tx_done = 1'b0;
  logic       irq_rx, irq_err, irq_txe, irq_tend;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  uart_regfile #(.ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .line_break(line_break), .tx_start(tx_start), .tx_data(tx_data),
    .tx_done(tx_done), .irq_rx(irq_rx), .irq_err(irq_err),
    .irq_txe(irq_txe), .irq_tend(irq_tend)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic rx_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse_break();
    @(negedge clk); line_break = 1'b1;
    @(negedge clk); line_break = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 mode", 4'd0, 8'h00);
    rd_chk("R1 rate", 4'd1, 8'hFF);
    rd_chk("R1 ctrl", 4'd2, 8'h00);
    rd_chk("R1 txd", 4'd3, 8'hFF);
    rd_chk("R1 stat", 4'd4, 8'h84);
    rd_chk("R1 rxd", 4'd5, 8'h00);
    rd_chk("R1 auxa", 4'd6, 8'h00);
    rd_chk("R1 auxb", 4'd7, 8'h00);
  endtask

  task automatic t_lock();
    wr(4'd0, 8'h5A); rd_chk("R2 mode open", 4'd0, 8'h5A);
    wr(4'd1, 8'h33); rd_chk("R2 rate open", 4'd1, 8'h33);
    wr(4'd2, 8'h10); wr(4'd0, 8'h11); rd_chk("R2 mode locked by rx", 4'd0, 8'h5A);
    wr(4'd2, 8'h20); wr(4'd1, 8'h44); rd_chk("R2 rate locked by tx", 4'd1, 8'h33);
    wr(4'd2, 8'h00);
  endtask

  task automatic t_rx();
    chk("R3 ready off", {7'd0, rx_ready}, 8'h00);
    wr(4'd2, 8'h50);
    chk("R3 ready on", {7'd0, rx_ready}, 8'h01);
    rx_byte(8'hA5);
    chk("R3 rx pulse", {7'd0, irq_rx}, 8'h01);
    @(negedge clk);
    chk("R3 rx pulse ends", {7'd0, irq_rx}, 8'h00);
    rd_chk("R3 full flag", 4'd4, 8'hC4);
    rd_chk("R5 rxd value", 4'd5, 8'hA5);
    rd_chk("R5 full cleared", 4'd4, 8'h84);
  endtask

  task automatic t_overrun();
    rx_byte(8'h11);
    rx_byte(8'h22);
    chk("R4 err irq", {7'd0, irq_err}, 8'h01);
    rd_chk("R4 overrun flag", 4'd4, 8'hE4);
    rd_chk("R4 data kept", 4'd5, 8'h11);
    wr(4'd4, 8'h00);
    chk("R7 release after read", {7'd0, irq_err}, 8'h00);
    rd_chk("R7 err cleared", 4'd4, 8'h84);
    rx_byte(8'h33);
    rx_byte(8'h44);
    chk("R4 err irq again", {7'd0, irq_err}, 8'h01);
    wr(4'd4, 8'h00);
    chk("R7 no release w/o err snapshot", {7'd0, irq_err}, 8'h01);
    wr(4'd2, 8'h10);
    chk("R9 rie clear drops err", {7'd0, irq_err}, 8'h00);
    rd_chk("R5 rxd before write", 4'd5, 8'h33);
    wr(4'd5, 8'h77);
    rd_chk("R5 rxd write ignored", 4'd5, 8'h33);
    rx_byte(8'h55);
    chk("R3 no pulse rie off", {7'd0, irq_rx}, 8'h00);
    rd_chk("R5 read rxd", 4'd5, 8'h55);
    wr(4'd2, 8'h00);
    rx_byte(8'h66);
    rd_chk("R3 rx ignored when disabled", 4'd4, 8'h84);
  endtask

  task automatic t_stat_write();
    wr(4'd4, 8'hFF);
    rd_chk("R6 masked write", 4'd4, 8'hBD);
    chk("R6 no err irq", {7'd0, irq_err}, 8'h00);
    wr(4'd4, 8'h00);
    rd_chk("R6 restore", 4'd4, 8'h84);
  endtask

  task automatic t_break();
    wr(4'd2, 8'h50);
    pulse_break();
    chk("R8 break irq", {7'd0, irq_err}, 8'h01);
    rd_chk("R8 framing flag", 4'd4, 8'h94);
    wr(4'd4, 8'h00);
    chk("R7 break release", {7'd0, irq_err}, 8'h00);
    wr(4'd2, 8'h10);
    pulse_break();
    chk("R8 no irq rie off", {7'd0, irq_err}, 8'h00);
    rd_chk("R8 flag rie off", 4'd4, 8'h94);
    wr(4'd4, 8'h00);
    wr(4'd2, 8'h00);
  endtask

  task automatic t_tx();
    wr(4'd2, 8'hA4);
    chk("R9 te pulse", {7'd0, irq_txe}, 8'h01);
    rd_chk("R9 te flags", 4'd4, 8'h84);
    wr(4'd3, 8'h3C);
    chk("R10 start", {7'd0, tx_start}, 8'h01);
    chk("R10 data", tx_data, 8'h3C);
    chk("R10 txe pulse", {7'd0, irq_txe}, 8'h01);
    rd_chk("R10 launched flags", 4'd4, 8'h80);
    wr(4'd3, 8'h5D);
    chk("R10 no start busy", {7'd0, tx_start}, 8'h00);
    rd_chk("R10 pending flags", 4'd4, 8'h00);
    pulse_done();
    chk("R11 relaunch", {7'd0, tx_start}, 8'h01);
    chk("R11 relaunch data", tx_data, 8'h5D);
    rd_chk("R11 relaunch flags", 4'd4, 8'h80);
    pulse_done();
    chk("R11 tend irq", {7'd0, irq_tend}, 8'h01);
    rd_chk("R11 idle flags", 4'd4, 8'h84);
    chk("R11 tend irq level", {7'd0, irq_tend}, 8'h01);
    wr(4'd2, 8'hA0);
    chk("R9 teie clear drops tend", {7'd0, irq_tend}, 8'h00);
    wr(4'd2, 8'h00);
  endtask

  task automatic t_unimpl();
    rd_chk("R12 read 9", 4'd9, 8'hFF);
    rd_chk("R12 read 15", 4'd15, 8'hFF);
    wr(4'd8, 8'h12);
    rd_chk("R12 no alias mode", 4'd0, 8'h5A);
    wr(4'd14, 8'h34);
    rd_chk("R12 no alias auxa", 4'd6, 8'h00);
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lock();
    t_rx();
    t_overrun();
    t_stat_write();
    t_break();
    t_tx();
    t_unimpl();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule